// File: doc/BRIEF.md
# Processor C-State Stop-Clock Controller

This block follows the processor power state among three levels: fully running (C0), auto-halted (C1) and stop-clock (C2). It drives an active-low stop-clock request toward the processor. The request is held low for as long as the processor stays in C2, which halts the processor's instruction stream. The processor reaches C1 by raising its halt indication. It reaches C2 by reading a dedicated level-2 I/O register. That read returns all-zero data.

While the block is in C2 it watches a fixed group of wake sources: interrupt lines, the SCI, an NMI/SMI request, an INIT request and a processor pending-break indication. Each source has its own mask or enable, and the block acts only on a source that passes its gate. A qualifying event sends the block back to C0 and releases stop-clock. In APIC mode there are 24 interrupt lines. In legacy PIC mode there are 16, and the upper eight lines are ignored. Wake events that arrive in C1 are left to the processor. C1 ends when the halt indication drops.

Top module: `cstate_clk_ctl`

## Requirements
- R1: After reset, `state_o` reads C0 and `stpclk_n_o` is high. The state codes are C0=0, C1=1 and C2=2.
- R2: In C0, with no level-2 read, a high `halt_i` moves the state to C1 at the next clock edge.
- R3: In C0, a level-2 read strobe with no break event in the same cycle moves the state to C2. `stpclk_n_o` goes low at that same edge, which is the edge that completes the read.
- R4: `stpclk_n_o` is low exactly while the state is C2. It falls only after a level-2 read and rises only after a break event.
- R5: In C2, a low-to-high transition on an interrupt line whose mask bit is 0 returns the state to C0 at the next edge. A transition on a line whose mask bit is 1 has no effect.
- R6: When `apic_mode_i` is 0, only interrupt lines 0 to 15 can break C2. When it is 1, all 24 lines can.
- R7: A rising edge on `sci_i` is a break event when `sci_mask_i` is 0. When `sci_mask_i` is 1 it is ignored.
- R8: A high NMI/SMI request or a high INIT request is a break event when its own enable is 1, and is ignored when the enable is 0.
- R9: The pending-break indication is a break event only when `pbe_brk_en_i` is 1.
- R10: In C1, break events have no effect. The state returns to C0 when `halt_i` is low.
- R11: A break event in the same cycle as the level-2 read cancels C2 entry. The state stays C0 and `stpclk_n_o` never goes low.
- R12: While the level-2 read strobe is high, `rd_data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Processor auto-halt indication |
| lvl2_rd_i | input | 1 | Single-cycle strobe for a read of the level-2 register |
| rd_data_o | output | DATA_W | Read data for the level-2 register, always zero |
| apic_mode_i | input | 1 | 1 = 24 interrupt lines are active, 0 = 16 lines |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| irq_mask_i | input | NUM_IRQ | Per-line mask, 1 = masked |
| sci_i | input | 1 | SCI request |
| sci_mask_i | input | 1 | 1 = SCI is masked |
| nmi_smi_req_i | input | 1 | Internal NMI/SMI request |
| nmi_smi_en_i | input | 1 | Enable for the NMI/SMI request as a break event |
| init_req_i | input | 1 | INIT request, for example from a keyboard-controller reset |
| init_en_i | input | 1 | Enable for the INIT request as a break event |
| pbe_i | input | 1 | Processor pending-break indication |
| pbe_brk_en_i | input | 1 | Error-pin break enable for the pending-break indication |
| state_o | output | 2 | Current power state (C0=0, C1=1, C2=2) |
| stpclk_n_o | output | 1 | Active-low stop-clock request |

## Verification
The hardest case to reach is a break event and the level-2 read landing in the same clock cycle. The bench creates it by raising an interrupt line in the same cycle as the read strobe, so the race is exact, and then checks that stop-clock stays high for that cycle and the one after. A second hard case is a masked line, or an upper line in legacy mode, that rises while the block is in C2. The bench clears each such line before it enables the next source. This way every later wake comes from a fresh rising edge and not from a level that was already present.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    CST_C0 = 2'd0,
    CST_C1 = 2'd1,
    CST_C2 = 2'd2
  } cst_state_e;
endpackage

// File: rtl/cst_break_detect.sv
module cst_break_detect #(
  parameter int NUM_IRQ    = 24,
  parameter int LEGACY_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apic_mode_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               sci_i,
  input  logic               sci_mask_i,
  input  logic               nmi_smi_req_i,
  input  logic               nmi_smi_en_i,
  input  logic               init_req_i,
  input  logic               init_en_i,
  input  logic               pbe_i,
  input  logic               pbe_brk_en_i,
  output logic               break_o
);
  logic [NUM_IRQ-1:0] irq_q;
  logic [NUM_IRQ-1:0] line_en;
  logic               sci_q;
  logic               irq_evt;
  logic               sci_evt;

  // Lines at or above LEGACY_IRQ exist only in APIC mode
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
    if (gi < LEGACY_IRQ) begin : g_legacy
      assign line_en[gi] = 1'b1;
    end else begin : g_apic
      assign line_en[gi] = apic_mode_i;
    end
  end

  // Previous-cycle copies for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      sci_q <= 1'b0;
    end else begin
      irq_q <= irq_i;
      sci_q <= sci_i;
    end
  end

  always_comb begin
    irq_evt = |(irq_i & ~irq_q & ~irq_mask_i & line_en);
    sci_evt = sci_i & ~sci_q & ~sci_mask_i;
    break_o = irq_evt | sci_evt
            | (nmi_smi_req_i & nmi_smi_en_i)
            | (init_req_i & init_en_i)
            | (pbe_i & pbe_brk_en_i);
  end
endmodule

// File: rtl/cst_fsm.sv
module cst_fsm
  import cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  logic       lvl2_rd_i,
  input  logic       break_i,
  output cst_state_e state_o,
  output logic       stpclk_n_o
);
  cst_state_e state_q, state_d;
  logic       stpclk_n_q, stpclk_n_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CST_C0: begin
        if (lvl2_rd_i && !break_i) state_d = CST_C2;
        else if (halt_i)           state_d = CST_C1;
      end
      CST_C1: if (!halt_i)  state_d = CST_C0;
      CST_C2: if (break_i)  state_d = CST_C0;
      default:              state_d = CST_C0;
    endcase
    stpclk_n_d = (state_d != CST_C2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CST_C0;
      stpclk_n_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      stpclk_n_q <= stpclk_n_d;
    end
  end

  assign state_o    = state_q;
  assign stpclk_n_o = stpclk_n_q;

  a_r3_enter_c2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CST_C0 && lvl2_rd_i && !break_i) |=> (state_q == CST_C2 && !stpclk_n_q));
  a_r4_fall_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stpclk_n_q) |-> $past(lvl2_rd_i));
  a_r4_rise_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stpclk_n_q) |-> $past(break_i));
  a_r5_exit_c2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CST_C2 && break_i) |=> (state_q == CST_C0 && stpclk_n_q));
  a_r10_c1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CST_C1 && halt_i) |=> (state_q == CST_C1));
  a_r11_race_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CST_C0 && lvl2_rd_i && break_i) |=> stpclk_n_q);
endmodule

// File: rtl/cstate_clk_ctl.sv
module cstate_clk_ctl
  import cst_pkg::*;
#(
  parameter int NUM_IRQ    = 24,
  parameter int LEGACY_IRQ = 16,
  parameter int DATA_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_i,
  input  logic               lvl2_rd_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               apic_mode_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               sci_i,
  input  logic               sci_mask_i,
  input  logic               nmi_smi_req_i,
  input  logic               nmi_smi_en_i,
  input  logic               init_req_i,
  input  logic               init_en_i,
  input  logic               pbe_i,
  input  logic               pbe_brk_en_i,
  output logic [1:0]         state_o,
  output logic               stpclk_n_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       brk;
  cst_state_e st;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cst_break_detect #(
    .NUM_IRQ    (NUM_IRQ),
    .LEGACY_IRQ (LEGACY_IRQ)
  ) u_brk (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .apic_mode_i   (apic_mode_i),
    .irq_i         (irq_i),
    .irq_mask_i    (irq_mask_i),
    .sci_i         (sci_i),
    .sci_mask_i    (sci_mask_i),
    .nmi_smi_req_i (nmi_smi_req_i),
    .nmi_smi_en_i  (nmi_smi_en_i),
    .init_req_i    (init_req_i),
    .init_en_i     (init_en_i),
    .pbe_i         (pbe_i),
    .pbe_brk_en_i  (pbe_brk_en_i),
    .break_o       (brk)
  );

  cst_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .halt_i     (halt_i),
    .lvl2_rd_i  (lvl2_rd_i),
    .break_i    (brk),
    .state_o    (st),
    .stpclk_n_o (stpclk_n_o)
  );

  assign state_o   = st;
  // Level-2 register reads as zero (R12)
  assign rd_data_o = '0;
endmodule

// File: tb/cstate_clk_ctl_test.sv
module cstate_clk_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        halt, lvl2, apic, sci, sci_m, nmi, nmi_en, init, init_en, pbe, pbe_en;
  logic [23:0] irq, irq_m;
  logic [7:0]  rd_data;
  logic [1:0]  state;
  logic        stp_n;

  int errors = 0;
  int checks = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  cstate_clk_ctl uut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt), .lvl2_rd_i(lvl2), .rd_data_o(rd_data),
    .apic_mode_i(apic), .irq_i(irq), .irq_mask_i(irq_m), .sci_i(sci), .sci_mask_i(sci_m),
    .nmi_smi_req_i(nmi), .nmi_smi_en_i(nmi_en), .init_req_i(init), .init_en_i(init_en),
    .pbe_i(pbe), .pbe_brk_en_i(pbe_en), .state_o(state), .stpclk_n_o(stp_n)
  );

  always #10 clk = ~clk;

  task automatic check_out(input logic [1:0] es, input string tag);
    checks++;
    if (state !== es || stp_n !== (es != 2'd2)) begin
      errors++;
      $display("FAIL %s: state=%0d stpclk_n=%0b expected state=%0d stpclk_n=%0b",
               tag, state, stp_n, es, (es != 2'd2));
    end
  endtask

  // Monitor: pops one expected item per clock edge and compares mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check_out(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // Driver: called at a falling edge with inputs set; queues the expected result
  task automatic cyc(input logic [1:0] es, input string tag);
    if (lvl2) begin
      checks++;
      if (rd_data !== 8'h00) begin
        errors++;
        $display("FAIL R12: rd_data=%h expected 00", rd_data);
      end
    end
    exp_q.push_back(es);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {halt, lvl2, apic, sci, sci_m, nmi, nmi_en, init, init_en, pbe, pbe_en} = '0;
    irq = '0; irq_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out(2'd0, "R1");

    // C1 entry, break ignored, exit
    halt = 1; cyc(2'd1, "R2");
    irq[0] = 1; nmi = 1; nmi_en = 1; cyc(2'd1, "R10");
    irq[0] = 0; nmi = 0; nmi_en = 0; cyc(2'd1, "R10");
    halt = 0; cyc(2'd0, "R10");

    // C2 entry, masked line, unmasked wake
    lvl2 = 1; cyc(2'd2, "R3");
    lvl2 = 0; cyc(2'd2, "R4");
    irq_m[3] = 1; irq[3] = 1; cyc(2'd2, "R5");
    irq[3] = 0; irq_m[3] = 0; cyc(2'd2, "R5");
    irq[5] = 1; cyc(2'd0, "R5");
    irq[5] = 0; cyc(2'd0, "R4");

    // legacy vs APIC line count
    apic = 0; lvl2 = 1; cyc(2'd2, "R3");
    lvl2 = 0; irq[20] = 1; cyc(2'd2, "R6");
    irq[20] = 0; cyc(2'd2, "R6");
    apic = 1; irq[20] = 1; cyc(2'd0, "R6");
    irq[20] = 0; cyc(2'd0, "R6");

    // SCI
    lvl2 = 1; cyc(2'd2, "R3");
    lvl2 = 0; sci_m = 1; sci = 1; cyc(2'd2, "R7");
    sci = 0; sci_m = 0; cyc(2'd2, "R7");
    sci = 1; cyc(2'd0, "R7");
    sci = 0; cyc(2'd0, "R7");

    // NMI/SMI and INIT
    lvl2 = 1; cyc(2'd2, "R3");
    lvl2 = 0; nmi = 1; cyc(2'd2, "R8");
    nmi_en = 1; cyc(2'd0, "R8");
    nmi = 0; nmi_en = 0; lvl2 = 1; cyc(2'd2, "R3");
    lvl2 = 0; init = 1; cyc(2'd2, "R8");
    init_en = 1; cyc(2'd0, "R8");
    init = 0; init_en = 0;

    // pending-break gating
    lvl2 = 1; cyc(2'd2, "R3");
    lvl2 = 0; pbe = 1; cyc(2'd2, "R9");
    pbe_en = 1; cyc(2'd0, "R9");
    pbe = 0; pbe_en = 0;

    // break in the same cycle as the level-2 read
    lvl2 = 1; irq[1] = 1; cyc(2'd0, "R11");
    lvl2 = 0; irq[1] = 0; cyc(2'd0, "R11");
    cyc(2'd0, "R11");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule